// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM command sequencer must spend a slot on an auto-refresh, and it shares the sequencer between those refreshes and host accesses. A programmable period sets the number of clock cycles between refreshes. A down-counter loads the period and reloads it each time it runs out. Each expiry marks a refresh as pending. The SDRAM device steps through its own refresh rows, so the block produces no address, only a request. The request stays high until the sequencer returns a one-cycle done pulse.

Host accesses use a valid/ready handshake. After the sequencer accepts an access, the block holds ready low until the sequencer reports the access finished with a separate done pulse. A pending refresh wins over any new host access. It never cuts short an access that has already started, so a refresh can be delayed for as long as that access lasts.

If the timer expires again while the previous refresh is still pending, a sticky miss flag is set. Reading status clears the flag. The interrupt output is the flag gated by an enable input.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With a non-zero period P and no competing host traffic, successive rising edges of `ref_req_o` are exactly P cycles apart.
- R2: A write to the period loads the counter at once. With a write of value P sampled at clock edge k and the sequencer idle, `ref_req_o` first rises in the cycle after edge k+P+1.
- R3: A period of zero stops expiries, so no new refresh request is raised.
- R4: `ref_req_o` stays high until a cycle in which `ref_done_i` is high, and is low in the cycle that follows.
- R5: `host_ready_o` is low whenever a refresh is pending or granted, and the sequencer is idle, so a pending refresh is granted ahead of a waiting host access.
- R6: After a host access is accepted (`host_valid_i` and `host_ready_o` high at an edge), neither `host_ready_o` nor `ref_req_o` goes high until `acc_done_i` has been seen.
- R7: `host_ready_o` is low in every cycle from the refresh grant through the cycle carrying `ref_done_i`.
- R8: A timer expiry while an earlier refresh is pending and not finishing in that cycle sets `status_o` to 1 on the next cycle.
- R9: A cycle with `status_rd_i` high clears `status_o` for the next cycle, unless a new miss occurs in that same cycle, in which case `status_o` stays 1.
- R10: `irq_o` equals `status_o` AND `irq_en_i`.
- R11: After reset, `status_o` is 0, `ref_req_o` is 0, `host_ready_o` is 1, and the counter starts from the period's reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_wr_i | input | 1 | Write strobe for the refresh period |
| period_data_i | input | PERIOD_W | New refresh period in cycles; 0 disables |
| irq_en_i | input | 1 | Interrupt enable |
| status_rd_i | input | 1 | Status read strobe; clears the miss flag |
| status_o | output | 1 | Sticky missed-refresh flag |
| irq_o | output | 1 | Missed-refresh interrupt |
| ref_req_o | output | 1 | Auto-refresh request to the sequencer |
| ref_done_i | input | 1 | Sequencer pulse: auto-refresh issued |
| host_valid_i | input | 1 | Host access request |
| host_ready_o | output | 1 | Host access accepted when high with valid |
| acc_done_i | input | 1 | Sequencer pulse: host access finished |

## Verification
The bench attacks the exact expiry phase after a period write. A counter that reloads one cycle late, or ignores the write, shifts the first request and fails the interval check. It holds a host access across two expiries to force a miss. A design that aborted the access, or raised the request mid-access, breaks the per-cycle comparison on ready and request. It pulses the status read on every cycle while misses keep arriving with the refresh stalled. A flag that clears on the read without honouring a simultaneous miss would read 0 where 1 is due. Back-to-back host traffic with refreshes interleaved checks that a pending refresh is granted ahead of the host and that it never runs while an access is still in flight.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_HOST = 2'd1,
    ARB_REF  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/sref_timer.sv
module sref_timer #(
  parameter int unsigned          PERIOD_W   = 16,
  parameter logic [PERIOD_W-1:0]  PERIOD_RST = 16'd1560
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [PERIOD_W-1:0] wdata_i,
  output logic                expire_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] period_q, cnt_q;

  // a write in the same cycle wins over expiry
  assign expire_o = !wr_i && (period_q != '0) && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= PERIOD_RST;
      cnt_q    <= PERIOD_RST;
    end else if (wr_i) begin
      period_q <= wdata_i;
      cnt_q    <= wdata_i;
    end else if (period_q != '0) begin
      cnt_q <= (cnt_q == ONE) ? period_q : cnt_q - ONE;
    end
  end

  // R2
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));

  // R3
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q == '0) |-> !expire_o);
endmodule

// File: rtl/sref_arb.sv
module sref_arb
  import sref_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic host_valid_i,
  input  logic acc_done_i,
  input  logic ref_done_i,
  output logic host_ready_o,
  output logic ref_req_o,
  output logic ref_pend_o,
  output logic ref_fin_o
);
  arb_state_e state_q, state_d;
  logic       pend_q;

  assign ref_fin_o    = (state_q == ARB_REF) && ref_done_i;
  assign ref_pend_o   = pend_q;
  assign ref_req_o    = (state_q == ARB_REF);
  assign host_ready_o = (state_q == ARB_IDLE) && !pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: if (pend_q) state_d = ARB_REF;
                else if (host_valid_i) state_d = ARB_HOST;
      ARB_HOST: if (acc_done_i) state_d = ARB_IDLE;
      ARB_REF:  if (ref_done_i) state_d = ARB_IDLE;
      default:  state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (expire_i)       pend_q <= 1'b1;
      else if (ref_fin_o) pend_q <= 1'b0;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_done_i) |=> ref_req_o);

  // R4
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && ref_done_i) |=> !ref_req_o);

  // R6
  host_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_i && host_ready_o) |=> (!ref_req_o && !host_ready_o));

  // R7
  ref_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> !host_ready_o);
endmodule

// File: rtl/sref_err.sv
module sref_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic pend_i,
  input  logic fin_i,
  input  logic rd_i,
  input  logic irq_en_i,
  output logic err_o,
  output logic irq_o
);
  logic err_q, miss;

  // expiry while the prior refresh is still outstanding
  assign miss  = expire_i && pend_i && !fin_i;
  assign err_o = err_q;
  assign irq_o = err_q && irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= miss || (err_q && !rd_i);
  end

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !rd_i) |=> err_q);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int unsigned          PERIOD_W   = 16,
  parameter logic [PERIOD_W-1:0]  PERIOD_RST = 16'd1560
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                period_wr_i,
  input  logic [PERIOD_W-1:0] period_data_i,
  input  logic                irq_en_i,
  input  logic                status_rd_i,
  output logic                status_o,
  output logic                irq_o,
  output logic                ref_req_o,
  input  logic                ref_done_i,
  input  logic                host_valid_i,
  output logic                host_ready_o,
  input  logic                acc_done_i
);
  logic expire, ref_pend, ref_fin;

  sref_timer #(.PERIOD_W(PERIOD_W), .PERIOD_RST(PERIOD_RST)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (period_wr_i),
    .wdata_i  (period_data_i),
    .expire_o (expire)
  );

  sref_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (expire),
    .host_valid_i (host_valid_i),
    .acc_done_i   (acc_done_i),
    .ref_done_i   (ref_done_i),
    .host_ready_o (host_ready_o),
    .ref_req_o    (ref_req_o),
    .ref_pend_o   (ref_pend),
    .ref_fin_o    (ref_fin)
  );

  sref_err u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .pend_i   (ref_pend),
    .fin_i    (ref_fin),
    .rd_i     (status_rd_i),
    .irq_en_i (irq_en_i),
    .err_o    (status_o),
    .irq_o    (irq_o)
  );

  // R8
  miss_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ref_pend && !(ref_req_o && ref_done_i)) |=> status_o);

  // R9
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !(expire && ref_pend)) |=> !status_o);

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_o && irq_en_i));

  // R5
  pend_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pend |-> !host_ready_o);
endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int P_RST = 20;

  logic clk_i = 0, rst_ni = 0;
  logic period_wr_i = 0, irq_en_i = 0, status_rd_i = 0;
  logic [PW-1:0] period_data_i = '0;
  logic ref_done_i = 0, host_valid_i = 0, acc_done_i = 0;
  logic status_o, irq_o, ref_req_o, host_ready_o;

  sdram_refresh_sched #(.PERIOD_W(PW), .PERIOD_RST(PW'(P_RST))) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model state
  int m_per = P_RST, m_el = 0, m_st = 0;
  bit m_pend = 0, m_err = 0;

  always @(posedge clk_i) begin
    bit ex, fin, miss;
    cyc++;
    if (!rst_ni) begin
      m_per = P_RST; m_el = 0; m_st = 0; m_pend = 0; m_err = 0;
    end else begin
      ex = 0;
      if (period_wr_i) begin
        m_per = int'(period_data_i); m_el = 0;
      end else if (m_per != 0) begin
        if (m_el == m_per - 1) begin ex = 1; m_el = 0; end
        else m_el++;
      end
      fin  = (m_st == 2) && ref_done_i;
      miss = ex && m_pend && !fin;
      m_err = miss || (m_err && !status_rd_i);
      case (m_st)
        0: if (m_pend) m_st = 2; else if (host_valid_i) m_st = 1;
        1: if (acc_done_i) m_st = 0;
        2: if (ref_done_i) m_st = 0;
        default: m_st = 0;
      endcase
      if (ex) m_pend = 1;
      else if (fin) m_pend = 0;
    end
  end

  // per-cycle comparison and request-edge tracking
  int rise_cnt = 0, last_rise = 0, rise_gap = 0;
  bit prev_req = 0;
  always @(negedge clk_i) begin
    chk("R5 R6 R7 host_ready", host_ready_o, (m_st == 0 && !m_pend));
    chk("R1 R4 ref_req", ref_req_o, (m_st == 2));
    chk("R8 R9 status", status_o, m_err);
    chk("R10 irq", irq_o, (m_err && irq_en_i));
    if (ref_req_o && !prev_req) begin
      rise_gap = cyc - last_rise;
      last_rise = cyc;
      rise_cnt++;
    end
    prev_req = ref_req_o;
  end

  // sequencer responder
  int ref_lat = 2, acc_lat = 3, rcnt = 0, hcnt = 0;
  bit hbusy = 0;
  always @(posedge clk_i) begin
    if (host_valid_i && host_ready_o) begin hbusy = 1; hcnt = 0; end
    #1;
    if (ref_req_o && !ref_done_i) begin
      rcnt++;
      ref_done_i = (rcnt >= ref_lat);
    end else begin
      ref_done_i = 0; rcnt = 0;
    end
    acc_done_i = 0;
    if (hbusy) begin
      hcnt++;
      if (hcnt >= acc_lat) begin acc_done_i = 1; hbusy = 0; end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic write_period(int p, output int wcyc);
    period_wr_i = 1; period_data_i = PW'(p);
    step(1);
    wcyc = cyc;
    period_wr_i = 0;
  endtask

  task automatic host_access(int lat);
    acc_lat = lat;
    host_valid_i = 1;
    do @(posedge clk_i); while (!host_ready_o);
    #1 host_valid_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    int wc, n0;
    step(3);
    rst_ni = 1;
    @(negedge clk_i);
    // R11
    chk("R11 ready", host_ready_o, 1);
    chk("R11 req", ref_req_o, 0);
    chk("R11 status", status_o, 0);
    step(1);
    irq_en_i = 1;

    // R11 + R1: first request from reset value, then fixed spacing
    wait (rise_cnt >= 3);
    chk("R1 gap", rise_gap, P_RST);

    // R2: reload on write
    step(4);
    write_period(12, wc);
    n0 = rise_cnt;
    wait (rise_cnt == n0 + 1);
    chk("R2 first", last_rise - wc, 13);
    wait (rise_cnt == n0 + 2);
    chk("R1 gap12", rise_gap, 12);

    // R3: zero disables
    step(5);
    write_period(0, wc);
    n0 = rise_cnt;
    step(80);
    chk("R3 no req", rise_cnt, n0);

    // R6, R8: long access spans two expiries
    write_period(10, wc);
    step(2);
    host_access(25);
    step(30);
    @(negedge clk_i);
    chk("R8 status", status_o, 1);
    chk("R10 irq on", irq_o, 1);
    step(1);
    irq_en_i = 0;
    @(negedge clk_i);
    chk("R10 irq off", irq_o, 0);
    step(1);
    irq_en_i = 1;

    // R9: plain read clears
    status_rd_i = 1;
    step(1);
    status_rd_i = 0;
    @(negedge clk_i);
    chk("R9 clear", status_o, 0);

    // R9: stuck refresh, reads collide with misses
    step(1);
    ref_lat = 100000;
    write_period(4, wc);
    step(10);
    status_rd_i = 1;
    step(12);
    status_rd_i = 0;
    step(2);
    @(negedge clk_i);
    chk("R9 sticky", status_o, 1);
    step(1);
    ref_lat = 2;
    step(6);

    // R5: continuous host traffic with refreshes interleaved
    write_period(10, wc);
    status_rd_i = 1; step(1); status_rd_i = 0;
    n0 = rise_cnt;
    acc_lat = 3;
    host_valid_i = 1;
    step(60);
    host_valid_i = 0;
    step(6);
    chk("R5 refresh served", int'(rise_cnt > n0), 1);

    step(4);
    wrap_up();
  end
endmodule